// File: doc/BRIEF.md
# 32-bit Integer ALU with Signed Compare

This block is the combinational arithmetic logic unit of a small integer datapath. It takes two operand words and a 3-bit operation code. In the same cycle it returns a result word, a zero flag and a signed overflow flag. The operations are bitwise AND, bitwise OR, addition, subtraction and signed set-on-less-than.

A single ripple adder serves addition, subtraction and comparison. For subtraction the B operand is inverted and a carry-in of one enters the low bit. One control bit does both jobs. The signed compare uses that same subtractor: its less-than bit is the difference's sign XOR the difference's overflow, so operands of opposite sign and large magnitude still compare correctly. A branch-on-equal is formed by issuing a subtract and testing the zero flag.

Top module: `alu32_core`

## Requirements
- R1: Opcode 3'b000 gives result = A AND B, bit by bit.
- R2: Opcode 3'b001 gives result = A OR B, bit by bit.
- R3: Opcode 3'b010 gives result = (A + B) modulo 2^32.
- R4: Opcode 3'b110 gives result = (A - B) modulo 2^32.
- R5: Opcode 3'b111 gives result bit 0 = 1 when A < B as signed two's-complement values, else 0; result bits 31..1 are always 0.
- R6: The zero flag is 1 exactly when all 32 result bits are 0, for every opcode.
- R7: For opcode 3'b010 the overflow flag is 1 exactly when A and B have the same sign bit and the result's sign bit differs from it; operands of opposite sign never set it.
- R8: For opcodes 3'b110 and 3'b111 the overflow flag reports the signed overflow of A - B: it is 1 exactly when A and B differ in sign bit and the difference's sign bit differs from A's; operands of the same sign never set it.
- R9: For opcodes 3'b000 and 3'b001 the overflow flag is 0.
- R10: Opcodes 3'b011, 3'b100 and 3'b101 give result 0 and overflow 0, so the zero flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| op_i | input | 3 | Operation code |
| result_o | output | 32 | Selected result |
| zero_o | output | 1 | High when result is all zeros |
| ovf_o | output | 1 | Signed overflow of the adder operation |

## Verification
The compare result and the overflow flag arise together when a set-on-less-than is issued with operands of opposite sign whose difference exceeds the signed range. An example is the most negative value against a large positive one. In that case the raw sign of the difference is wrong and must be corrected by the overflow term. Directed vectors at the extremes of the signed range provoke this case, and random vectors are biased toward the extremes to provoke it again. Result, zero flag and overflow flag are each compared against an independent reference that uses plain signed arithmetic.

// File: rtl/alu32_pkg.sv
package alu32_pkg;
  typedef enum logic [2:0] {
    OPC_AND = 3'b000,
    OPC_OR  = 3'b001,
    OPC_ADD = 3'b010,
    OPC_SUB = 3'b110,
    OPC_SLT = 3'b111
  } alu_opc_e;

  typedef enum logic [2:0] {
    SEL_AND,
    SEL_OR,
    SEL_SUM,
    SEL_LESS,
    SEL_NONE
  } res_sel_e;

  typedef struct packed {
    res_sel_e sel;
    logic     binv;
    logic     ovf_en;
  } alu_ctrl_t;
endpackage

// File: rtl/alu32_decode.sv
module alu32_decode
  import alu32_pkg::*;
(
  input  logic [2:0] op_i,
  output alu_ctrl_t  ctrl_o
);
  always_comb begin
    ctrl_o = '{sel: SEL_NONE, binv: 1'b0, ovf_en: 1'b0};
    case (op_i)
      OPC_AND: ctrl_o.sel = SEL_AND;
      OPC_OR:  ctrl_o.sel = SEL_OR;
      OPC_ADD: ctrl_o = '{sel: SEL_SUM,  binv: 1'b0, ovf_en: 1'b1};
      OPC_SUB: ctrl_o = '{sel: SEL_SUM,  binv: 1'b1, ovf_en: 1'b1};
      OPC_SLT: ctrl_o = '{sel: SEL_LESS, binv: 1'b1, ovf_en: 1'b1};
      default: ctrl_o = '{sel: SEL_NONE, binv: 1'b0, ovf_en: 1'b0};
    endcase
  end
endmodule

// File: rtl/alu32_fa.sv
module alu32_fa (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  assign s_o = a_i ^ b_i ^ c_i;
  assign c_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
endmodule

// File: rtl/alu32_adder.sv
module alu32_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             binv_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             c_msb_o,  // carry into sign bit
  output logic             c_out_o
);
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   carry;

  assign b_eff    = b_i ^ {WIDTH{binv_i}};
  assign carry[0] = binv_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    alu32_fa u_fa (
      .a_i (a_i[i]),
      .b_i (b_eff[i]),
      .c_i (carry[i]),
      .s_o (sum_o[i]),
      .c_o (carry[i+1])
    );
  end

  assign c_msb_o = carry[WIDTH-1];
  assign c_out_o = carry[WIDTH];
endmodule

// File: rtl/alu32_core.sv
module alu32_core
  import alu32_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  alu_ctrl_t        ctrl;
  logic [WIDTH-1:0] sum;
  logic             c_msb;
  logic             c_out;
  logic             add_ovf;
  logic             less;

  alu32_decode u_dec (
    .op_i   (op_i),
    .ctrl_o (ctrl)
  );

  alu32_adder #(.WIDTH(WIDTH)) u_add (
    .a_i     (a_i),
    .b_i     (b_i),
    .binv_i  (ctrl.binv),
    .sum_o   (sum),
    .c_msb_o (c_msb),
    .c_out_o (c_out)
  );

  assign add_ovf = c_msb ^ c_out;
  // sign corrected by overflow: valid across the full signed range
  assign less    = sum[MSB] ^ add_ovf;

  always_comb begin
    unique case (ctrl.sel)
      SEL_AND:  result_o = a_i & b_i;
      SEL_OR:   result_o = a_i | b_i;
      SEL_SUM:  result_o = sum;
      SEL_LESS: result_o = {{(WIDTH-1){1'b0}}, less};
      default:  result_o = '0;
    endcase
  end

  assign zero_o = ~|result_o;
  assign ovf_o  = ctrl.ovf_en & add_ovf;
endmodule

// File: rtl/alu32_core_chk.sv
module alu32_core_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [2:0]       op_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o,
  input logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  logic known;
  assign known = !$isunknown({a_i, b_i, op_i, result_o, zero_o, ovf_o});

  always_comb begin
    if (known) begin
      if (op_i == 3'b000) p_and_r1: assert (result_o == (a_i & b_i));
      if (op_i == 3'b001) p_or_r2:  assert (result_o == (a_i | b_i));
      if (op_i == 3'b010) p_add_r3: assert (result_o == WIDTH'(a_i + b_i));
      if (op_i == 3'b110) p_sub_r4: assert (result_o == WIDTH'(a_i - b_i));
      if (op_i == 3'b111) p_slt_r5: assert (result_o[MSB:1] == '0);
      p_zero_r6: assert (zero_o == (result_o == '0));
      if (op_i == 3'b010 && a_i[MSB] != b_i[MSB])
        p_no_ovf_add_r7: assert (!ovf_o);
      if (op_i[2:1] == 2'b11 && a_i[MSB] == b_i[MSB])
        p_no_ovf_sub_r8: assert (!ovf_o);
      if (op_i[2:1] == 2'b00) p_no_ovf_logic_r9: assert (!ovf_o);
      if (op_i == 3'b011 || op_i == 3'b100 || op_i == 3'b101)
        p_unused_r10: assert (result_o == '0 && !ovf_o);
    end
  end
endmodule

bind alu32_core alu32_core_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i      (a_i),
  .b_i      (b_i),
  .op_i     (op_i),
  .result_o (result_o),
  .zero_o   (zero_o),
  .ovf_o    (ovf_o)
);

// File: tb/alu32_core_tb_top.sv
module alu32_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] a, b, res;
  logic [2:0]  op;
  logic        zero, ovf;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  alu32_core dut_i (
    .a_i      (a),
    .b_i      (b),
    .op_i     (op),
    .result_o (res),
    .zero_o   (zero),
    .ovf_o    (ovf)
  );

  function automatic logic [32:0] model(logic [2:0] o, logic [31:0] x, logic [31:0] y);
    logic [31:0] r;
    logic        v;
    r = '0; v = 1'b0;
    case (o)
      3'b000: r = x & y;
      3'b001: r = x | y;
      3'b010: begin r = x + y; v = (x[31] == y[31]) && (r[31] != x[31]); end
      3'b110: begin r = x - y; v = (x[31] != y[31]) && (r[31] != x[31]); end
      3'b111: begin
        r = ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
        v = (x[31] != y[31]) && (((x - y) >> 31) != {31'd0, x[31]});
      end
      default: begin r = '0; v = 1'b0; end
    endcase
    return {v, r};
  endfunction

  function automatic string res_tag(logic [2:0] o);
    case (o)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b110: return "R4";
      3'b111: return "R5";
      default: return "R10";
    endcase
  endfunction

  function automatic string ovf_tag(logic [2:0] o);
    case (o)
      3'b010: return "R7";
      3'b110, 3'b111: return "R8";
      3'b000, 3'b001: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h", tag, op, a, b, act, exp);
    end
  endtask

  task automatic apply(logic [2:0] o, logic [31:0] x, logic [31:0] y);
    logic [32:0] e;
    @(negedge clk);
    op = o; a = x; b = y;
    #1;
    e = model(o, x, y);
    chk(res_tag(o), res, e[31:0]);
    chk("R6", {31'd0, zero}, {31'd0, e[31:0] == 32'd0});
    chk(ovf_tag(o), {31'd0, ovf}, {31'd0, e[32]});
  endtask

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 5))
      0: return 32'h7fff_ffff - $urandom_range(0, 3);
      1: return 32'h8000_0000 + $urandom_range(0, 3);
      2: return $urandom_range(0, 7);
      3: return 32'hffff_ffff - $urandom_range(0, 3);
      default: return $urandom;
    endcase
  endfunction

  initial begin
    void'($urandom(32'd1234));
    a = '0; b = '0; op = 3'b000;
    #1;
    // reset state: zero operands, AND -> result 0, zero 1, no overflow
    chk("R1", res, 32'd0);
    chk("R6", {31'd0, zero}, 32'd1);
    chk("R9", {31'd0, ovf}, 32'd0);
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    apply(3'b000, 32'hf0f0_a5a5, 32'h0ff0_ffff);                 // R1
    apply(3'b001, 32'hf000_0000, 32'h0000_000f);                 // R2
    apply(3'b010, 32'h7fff_ffff, 32'h0000_0001);                 // R3 R7 overflow
    apply(3'b010, 32'h8000_0000, 32'h8000_0000);                 // R7 wrap to 0, R6
    apply(3'b010, 32'h7fff_ffff, 32'h8000_0000);                 // R7 opposite signs
    apply(3'b110, 32'h8000_0000, 32'h0000_0001);                 // R4 R8 overflow
    apply(3'b110, 32'h1234_5678, 32'h1234_5678);                 // R4 R6 equal
    apply(3'b110, 32'hffff_ffff, 32'h8000_0000);                 // R8 same sign
    apply(3'b111, 32'h8000_0000, 32'h7fff_ffff);                 // R5 less + ovf
    apply(3'b111, 32'h7fff_ffff, 32'h8000_0000);                 // R5 greater + ovf
    apply(3'b111, 32'hffff_ffff, 32'h0000_0001);                 // R5 signed -1 < 1
    apply(3'b111, 32'h0000_0005, 32'h0000_0005);                 // R5 equal -> 0
    apply(3'b011, 32'hffff_ffff, 32'hffff_ffff);                 // R10
    apply(3'b100, 32'h7fff_ffff, 32'h0000_0001);                 // R10
    apply(3'b101, 32'h8000_0000, 32'h7fff_ffff);                 // R10

    for (int i = 0; i < 2000; i++) begin
      logic [31:0] x, y;
      x = pick();
      y = ($urandom_range(0, 9) == 0) ? x : pick();
      apply(3'($urandom_range(0, 7)), x, y);
    end
    done = 1'b1;
  end

  initial begin
    fork
      begin
        repeat (50000) @(posedge clk);
        if (!done) begin
          checks++;
          fails++;
          $display("FAIL watchdog actual=running expected=done");
        end
      end
      wait (done);
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule